// File: doc/BRIEF.md
# Half-Buffer Bit-Reversal Output Reorderer

This block sits at the tail of a streaming FFT pipeline. It takes a serial stream of complex results that leaves the transform in a scrambled order and puts the samples back into natural order, X[0] through X[N-1], one sample per clock. It needs only N/2 complex words of storage, where a plain reorder buffer needs N.

The input order is defined per half-frame. Lower-half position c (the first N/2 samples of a frame) carries X[rev(c)]. Upper-half position c (the last N/2 samples) carries X[N/2 + rev(c)]. Here rev() mirrors the log2(N/2) bits of c. Each half-frame's samples are read out during the following half-frame, so the buffer is full at every half-frame boundary.

Every accepted sample first reads the word at its address and then overwrites that word in the same clock. The address sequence alternates between natural and bit-mirrored order on successive half-frames:
- Data written in natural order during a lower half is read back in mirrored order during the next upper half.
- Data written in mirrored order during an upper half is read back in natural order during the next lower half.

A small state machine keeps track of which half is running:
- **FILL**: the first lower half after reset, with output muted.
- **LOWER**: a lower half.
- **UPPER**: an upper half.

It has four transitions:
- **FILL→UPPER** and **LOWER→UPPER** are taken on the last lower-half position.
- **UPPER→LOWER** is taken on the last upper-half position.
- **SYNC**: an input start-of-frame puts the sample at lower-half position 0. The state stays FILL if the block has not yet primed, and otherwise becomes LOWER.

Top module: `half_bitrev_reorder`

## Requirements
- R1: While reset is asserted, and after its release until the first output, out_valid and out_sof are 0.
- R2: The first N/2 accepted input samples after reset (or after the sample flagged with in_sof, while not yet primed) produce no output; out_valid stays 0.
- R3: With input lower-half position c carrying X[rev(c)] and upper-half position c carrying X[N/2+rev(c)], where rev mirrors the log2(N/2) bits of c, the outputs form the sequence X[0], X[1], …, X[N-1] of each frame in natural order. The data on out_re/out_im equals the corresponding input in_re/in_im.
- R4: Once primed, each accepted input sample produces exactly one output sample on the next clock. X[j] for j < N/2 follows upper-half position j of the same frame. X[j] for j ≥ N/2 follows lower-half position j−N/2 of the next frame.
- R5: out_sof is 1 exactly with X[0] of each frame; consecutive out_sof pulses are N output samples apart.
- R6: Back-to-back frames without idle cycles give a gap-free output stream. After a run of frames the last N/2 samples remain held until the next frame pushes them out.
- R7: A cycle with in_valid low produces no output on the next clock and advances no position, so idle gaps anywhere in the stream leave the output sequence unchanged.
- R8: A sample with in_sof high is taken as lower-half position 0; unflagged samples received before it while not yet primed are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_sof | input | 1 | Input sample is position 0 of a frame |
| in_re | input | W | Input real part |
| in_im | input | W | Input imaginary part |
| out_valid | output | 1 | Output sample present this cycle |
| out_sof | output | 1 | Output sample is X[0] of a frame |
| out_re | output | W | Output real part |
| out_im | output | W | Output imaginary part |

## Verification
The reorder is tried with several patterns:
- **Unbroken back-to-back frames**: show that the natural/mirrored address alternation keeps working across frame boundaries.
- **Periodic idle gaps every cycle and every third cycle**: separate correct position counters from ones that advance on idle cycles.
- **Unflagged samples ahead of the first start-of-frame**: show that resynchronisation discards them.

Random frame data makes every misplaced sample visible as a value mismatch. The leftover half-frame at the end of each run confirms that exactly N/2 words are held.

// File: rtl/brv_pkg.sv
package brv_pkg;

    // Half-frame tracking states of the reorder controller
    typedef enum logic [1:0] {
        ST_FILL  = 2'd0,   // first lower half after reset, output muted
        ST_LOWER = 2'd1,   // lower half: natural address order
        ST_UPPER = 2'd2    // upper half: mirrored address order
    } brv_state_e;

endpackage

// File: rtl/brv_addr_rev.sv
module brv_addr_rev #(
    parameter int AW = 3
) (
    input  logic [AW-1:0] addr_i,
    output logic [AW-1:0] addr_o
);

    // Pure wiring: bit b of the output is bit AW-1-b of the input
    for (genvar b = 0; b < AW; b++) begin : g_mirror
        assign addr_o[b] = addr_i[AW-1-b];
    end

endmodule

// File: rtl/brv_swap_ram.sv
module brv_swap_ram #(
    parameter int DEPTH = 8,
    parameter int DW    = 32,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Old word is read out in the same cycle the new word replaces it
    always_ff @(posedge clk) begin
        if (en) begin
            rdata     <= mem[addr];
            mem[addr] <= wdata;
        end
    end

endmodule

// File: rtl/brv_ctrl.sv
module brv_ctrl
    import brv_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         in_sof,
    output logic [$clog2(N/2)-1:0]       addr,
    output logic                         emit,
    output logic                         emit_sof
);

    localparam int HALF = N / 2;
    localparam int AW   = $clog2(HALF);
    localparam logic [AW-1:0] LAST = AW'(HALF - 1);

    brv_state_e    state_q, state_d, eff_state;
    logic [AW-1:0] cnt_q, cnt_d, eff_cnt, rev_cnt;

    brv_addr_rev #(.AW(AW)) rev_i (
        .addr_i (eff_cnt),
        .addr_o (rev_cnt)
    );

    // Position of the current sample, with start-of-frame resync
    always_comb begin
        eff_state = state_q;
        eff_cnt   = cnt_q;
        if (in_sof) begin
            eff_cnt   = '0;
            eff_state = (state_q == ST_FILL) ? ST_FILL : ST_LOWER;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (in_valid) begin
            cnt_d   = eff_cnt + 1'b1;
            state_d = eff_state;
            if (eff_cnt == LAST) begin
                unique case (eff_state)
                    ST_FILL:  state_d = ST_UPPER;
                    ST_LOWER: state_d = ST_UPPER;
                    ST_UPPER: state_d = ST_LOWER;
                    default:  state_d = ST_FILL;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FILL;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        addr     = eff_cnt;
        emit     = 1'b0;
        emit_sof = 1'b0;
        unique case (eff_state)
            ST_FILL: begin
                addr = eff_cnt;
            end
            ST_LOWER: begin
                addr = eff_cnt;
                emit = in_valid;
            end
            ST_UPPER: begin
                addr     = rev_cnt;
                emit     = in_valid;
                emit_sof = in_valid && (eff_cnt == '0);
            end
            default: begin
                addr = eff_cnt;
            end
        endcase
    end

endmodule

// File: rtl/half_bitrev_reorder.sv
module half_bitrev_reorder #(
    parameter int N = 16,
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         in_sof,
    input  logic [W-1:0] in_re,
    input  logic [W-1:0] in_im,
    output logic         out_valid,
    output logic         out_sof,
    output logic [W-1:0] out_re,
    output logic [W-1:0] out_im
);

    localparam int HALF = N / 2;
    localparam int AW   = $clog2(HALF);
    localparam int DW   = 2 * W;

    logic [AW-1:0] addr;
    logic          emit, emit_sof;
    logic [DW-1:0] rdata;

    brv_ctrl #(.N(N)) ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .addr     (addr),
        .emit     (emit),
        .emit_sof (emit_sof)
    );

    brv_swap_ram #(.DEPTH(HALF), .DW(DW), .AW(AW)) ram_i (
        .clk   (clk),
        .en    (in_valid),
        .addr  (addr),
        .wdata ({in_re, in_im}),
        .rdata (rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
        end else begin
            out_valid <= emit;
            out_sof   <= emit_sof;
        end
    end

    assign out_re = rdata[DW-1:W];
    assign out_im = rdata[W-1:0];

endmodule

// File: rtl/brv_checker.sv
module brv_checker #(
    parameter int N = 16
) (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_sof,
    input logic out_valid,
    input logic out_sof
);

    localparam int HALF = N / 2;
    localparam int CW   = $clog2(N) + 1;

    logic [CW-1:0] acc_cnt, out_cnt;
    logic          seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            out_cnt <= '0;
            seen    <= 1'b0;
        end else begin
            if (in_valid && (acc_cnt < CW'(HALF)))
                acc_cnt <= acc_cnt + 1'b1;
            if (out_valid)
                out_cnt <= out_sof ? CW'(1) : out_cnt + 1'b1;
            if (out_sof)
                seen <= 1'b1;
        end
    end

    // R2
    fill_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sof && (acc_cnt < CW'(HALF))) |=> !out_valid);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5
    sof_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R5
    sof_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_sof && seen) |-> (out_cnt == CW'(N)));

    // R4
    sof_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> $past(in_valid));

endmodule

bind half_bitrev_reorder brv_checker #(.N(N)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sof    (in_sof),
    .out_valid (out_valid),
    .out_sof   (out_sof)
);

// File: tb/half_bitrev_reorder_tb_top.sv
module half_bitrev_reorder_tb_top;

    localparam int N    = 16;
    localparam int W    = 12;
    localparam int HALF = N / 2;
    localparam int AW   = $clog2(HALF);
    localparam int NSCN = 4;

    // Scenario table: data frames, idle gap period (0 = none), unflagged lead-in samples,
    // and expected samples left held at the end
    localparam int SCN_FR   [NSCN] = '{3, 2, 2, 3};
    localparam int SCN_GAP  [NSCN] = '{0, 3, 0, 1};
    localparam int SCN_JUNK [NSCN] = '{0, 0, 3, 0};
    localparam int SCN_LEFT [NSCN] = '{HALF, HALF, HALF, HALF};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic         rst_n, in_valid, in_sof;
    logic [W-1:0] in_re, in_im;
    logic         out_valid, out_sof;
    logic [W-1:0] out_re, out_im;

    half_bitrev_reorder #(.N(N), .W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_re(in_re), .in_im(in_im), .out_valid(out_valid), .out_sof(out_sof),
        .out_re(out_re), .out_im(out_im)
    );

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    int    cur_gap = 0;
    int    sent = 0;
    string tag = "R3";
    logic [2*W:0] exp_q[$];

    int bt_cnt;
    bit bt_primed;
    bit exp_ov;

    function automatic int rev_half(int c);
        int r = 0;
        for (int b = 0; b < AW; b++)
            if (c[b]) r = r | (1 << (AW - 1 - b));
        return r;
    endfunction

    function automatic void check(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endfunction

    // Expected output-valid per R2/R4/R7: one output per accepted input once N/2 taken
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_cnt    <= 0;
            bt_primed <= 1'b0;
            exp_ov    <= 1'b0;
        end else if (in_valid) begin
            exp_ov <= bt_primed;
            if (!bt_primed && ((in_sof ? 0 : bt_cnt) == HALF - 1))
                bt_primed <= 1'b1;
            bt_cnt <= ((in_sof ? 0 : bt_cnt) + 1) % HALF;
        end else begin
            exp_ov <= 1'b0;
        end
    end

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        logic [2*W:0] e;
        if (rst_n && !done) begin
            check(out_valid == exp_ov, "R2/R4/R7", "out_valid", longint'(out_valid), longint'(exp_ov));
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "output with nothing expected", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check({out_re, out_im} == e[2*W-1:0], tag, "sample",
                          longint'({out_re, out_im}), longint'(e[2*W-1:0]));
                    check(out_sof == e[2*W], "R5", "out_sof", longint'(out_sof), longint'(e[2*W]));
                end
            end
        end
    end

    task automatic put(logic [W-1:0] re, logic [W-1:0] im, logic sof);
        in_valid = 1'b1;
        in_sof   = sof;
        in_re    = re;
        in_im    = im;
        @(posedge clk); #1;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        sent++;
        if (cur_gap != 0 && (sent % cur_gap) == 0) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic drive_frame();
        logic [W-1:0] fr_re[N];
        logic [W-1:0] fr_im[N];
        for (int i = 0; i < N; i++) begin
            fr_re[i] = W'($urandom);
            fr_im[i] = W'($urandom);
            exp_q.push_back({(i == 0), fr_re[i], fr_im[i]});
        end
        for (int h = 0; h < 2; h++)
            for (int c = 0; c < HALF; c++)
                put(fr_re[h*HALF + rev_half(c)], fr_im[h*HALF + rev_half(c)], (h == 0 && c == 0));
    endtask

    task automatic do_reset();
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        // R1: outputs cleared while in reset
        check(out_valid == 1'b0, "R1", "out_valid in reset", longint'(out_valid), 0);
        check(out_sof == 1'b0, "R1", "out_sof in reset", longint'(out_sof), 0);
        exp_q.delete();
        sent  = 0;
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_sof   = 1'b0;
        in_re    = '0;
        in_im    = '0;

        for (int s = 0; s < NSCN; s++) begin
            do_reset();
            cur_gap = SCN_GAP[s];
            tag     = (SCN_JUNK[s] != 0) ? "R8" : "R3";
            for (int j = 0; j < SCN_JUNK[s]; j++)
                put(W'($urandom), W'($urandom), 1'b0);
            // last frame flushes the previous one and stays partly held
            for (int f = 0; f <= SCN_FR[s]; f++)
                drive_frame();
            repeat (3) @(posedge clk);
            #1;
            // R6: exactly the last half-frame remains held
            check(exp_q.size() == SCN_LEFT[s], "R6", "held samples at end",
                  longint'(exp_q.size()), longint'(SCN_LEFT[s]));
        end

        // R1: reset in the middle of a primed stream clears the outputs
        do_reset();
        cur_gap = 0;
        tag     = "R3";
        drive_frame();
        rst_n = 1'b0;
        #1;
        check(out_valid == 1'b0, "R1", "out_valid after mid-run reset", longint'(out_valid), 0);
        check(out_sof == 1'b0, "R1", "out_sof after mid-run reset", longint'(out_sof), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check(out_valid == 1'b0, "R1", "out_valid after release", longint'(out_valid), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule